// File: doc/BRIEF.md
# Southbound Command Frame Dispatcher

This block sits behind the deserializer of a buffered memory module link. It accepts one 10-bit transfer per clock. Twelve transfers make one frame, and the first is marked by a frame-start input. A command frame carries three 24-bit DRAM commands in slots A, B and C. The block unpacks them and steers each one to one of up to eight DRAM channel outputs, using the 3-bit channel select held in the command.

Slot A is on the latency-critical path. It has its own 14-bit CRC, which covers the first four transfers, so the block checks it and releases command A as soon as the fourth transfer has been taken in. Slots B and C are protected by a 22-bit CRC that covers the command bits of the whole frame. They are released one frame period (twelve clocks) after command A, and only if that CRC matches and the three commands select three different channels. Frames whose type field is not "command" are not decoded: the block notes them with a pulse and counts them.

The host schedules frames back to back. Because of that, the B and C commands of one frame go out in the same clock as command A of the next frame.

Top module: `sb_cmd_dispatch`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, every channel valid bit, every error pulse, the channel-clash pulse, the foreign-frame pulse and the foreign-frame count are zero. A transfer taken while reset is low has no effect.
- R2: In transfer t of a slot (t = 0..3), bit position k (0..5) carries command bit 4k+t. Slot A uses frame transfers 0–3, slot B uses 4–7 and slot C uses 8–11. Command bits 23:21 select the channel. Command A appears on that channel (valid high, command on its 24-bit slice of `chan_cmd`) in the clock after transfer 3 is taken.
- R3: The A check value is bit j at position 7+j/4 of transfer j%4 for j = 0..11, with bit 12 at position 6 of transfer 2 and bit 13 at position 6 of transfer 3. The CRC runs over transfers 0..3 in order. Within a transfer it takes positions 0 upward: positions 0–6 for transfers 0 and 1, positions 0–5 for transfers 2 and 3. It starts at zero and shifts MSB first (feedback = MSB xor input bit) with the polynomial x^14+x^5+x^3+x+1. On a mismatch, `crc_a_err` pulses in the clock after transfer 3 and no command of that frame is issued.
- R4: B and C appear on their selected channels exactly twelve clocks after command A appeared.
- R5: The frame check value is bit i at position 6+i%4 of transfer 4+i/4 for i = 0..21. The CRC runs over positions 0–5 of all twelve transfers in order, position 0 first, with x^22+x+1 and the same shift rule. On a mismatch after a good A check, `crc_f_err` pulses in the clock after transfer 11. B and C are never issued, and command A stays issued.
- R6: If any two of A, B and C in a frame carry the same channel select, and both CRCs match, `dimm_conflict` pulses in the clock after transfer 11 and B and C are not issued.
- R7: The frame type is position 6 of transfer 0 (bit 0) and of transfer 1 (bit 1), and 00 means a command frame. Any other value issues nothing and raises no CRC error. It pulses `foreign_frame` in the clock after transfer 3 and increments `foreign_count` by one.
- R8: When command A of a frame falls in the same clock as B or C of the previous frame, each is delivered if the channels differ. On a shared channel command A is delivered, the older command is dropped, and `chan_clash` pulses in that clock.
- R9: Transfers are taken only from a frame-start onward, until twelve have been taken. Transfers after that without a frame-start are ignored, and a frame-start in mid-frame restarts capture at transfer 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transfer clock |
| rst_n | input | 1 | Synchronous reset, active low |
| xfer_valid | input | 1 | A transfer is present on `xfer_data` |
| frame_start | input | 1 | This transfer is transfer 0 of a frame |
| xfer_data | input | 10 | One frame transfer |
| chan_valid | output | NCH (8) | Per-channel command strobe |
| chan_cmd | output | NCH*24 (192) | Per-channel command, channel n at bits 24n+23:24n |
| crc_a_err | output | 1 | A-slot CRC mismatch pulse |
| crc_f_err | output | 1 | Frame CRC mismatch pulse |
| dimm_conflict | output | 1 | Two slots of one frame share a channel |
| chan_clash | output | 1 | A new A command displaced an older B or C |
| foreign_frame | output | 1 | Non-command frame seen |
| foreign_count | output | CNT_W (16) | Number of non-command frames |

## Verification
The two functions that meet in one clock are the early issue of a new frame's command A and the delayed release of the previous frame's B and C. The bench sends three frames back to back. In the first pair all channels differ, and the cycle stamps logged per channel must show the older B/C and the newer A in the same clock. In the second pair the new A reuses the channel of the older B: that channel must carry the new A once, the older C must still arrive, and `chan_clash` must pulse in exactly that clock.

// File: rtl/sbd_pkg.sv
// Package: shared widths, frame geometry and command types of the southbound
// command dispatcher. Assumes a 10-bit transfer and twelve transfers per frame.
package sbd_pkg;
    localparam int XFER_W      = 10;
    localparam int LANE_W      = 6;   // command-bearing bit positions
    localparam int CTL_W       = 4;   // check/type bit positions
    localparam int SLOT_XFERS  = 4;
    localparam int NUM_SLOTS   = 3;
    localparam int FRAME_XFERS = SLOT_XFERS * NUM_SLOTS;
    localparam int IDX_W       = $clog2(FRAME_XFERS + 1);
    localparam int CMD_W       = 24;
    localparam int SEL_W       = 3;
    localparam int SEL_LSB     = CMD_W - SEL_W;
    localparam int CRC_A_W     = 14;
    localparam int CRC_F_W     = 22;
    localparam int FTYPE_W     = 2;

    typedef logic [CMD_W-1:0] cmd_t;
    typedef logic [SEL_W-1:0] sel_t;

    // Channel select carried in the top bits of a command.
    function automatic sel_t sel_of(input cmd_t c);
        return c[SEL_LSB +: SEL_W];
    endfunction
endpackage

// File: rtl/sbd_crc_step.sv
// Module: one clock's worth of a bit-serial CRC. Shifts the masked input bits,
// lowest index first, into the running remainder, MSB-first feedback.
// Assumes POLY holds the polynomial without its x^W term.
module sbd_crc_step #(
    parameter int          W    = 14,
    parameter logic [W-1:0] POLY = 14'h002B,
    parameter int          NB   = 7
) (
    input  logic [W-1:0]  crc_i,
    input  logic [NB-1:0] bits_i,
    input  logic [NB-1:0] mask_i,
    output logic [W-1:0]  crc_o
);
    logic [W-1:0] acc;
    logic         fb;

    // Purpose: fold the enabled bits into the remainder in index order.
    always_comb begin
        acc = crc_i;
        fb  = 1'b0;
        for (int k = 0; k < NB; k++) begin
            if (mask_i[k]) begin
                fb  = acc[W-1] ^ bits_i[k];
                acc = {acc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
            end
        end
        crc_o = acc;
    end
endmodule

// File: rtl/sbd_field_map.sv
// Module: pure wiring that unpacks a captured frame into its three commands,
// the two received check values and the frame type. Assumes the caller
// presents all twelve transfers, already split into command and control bits.
module sbd_field_map
    import sbd_pkg::*;
(
    input  logic [FRAME_XFERS*LANE_W-1:0] lanes_i,
    input  logic [FRAME_XFERS*CTL_W-1:0]  ctl_i,
    output cmd_t                          cmd_a_o,
    output cmd_t                          cmd_b_o,
    output cmd_t                          cmd_c_o,
    output logic [CRC_A_W-1:0]            a_chk_o,
    output logic [CRC_F_W-1:0]            f_chk_o,
    output logic [FTYPE_W-1:0]            ftype_o
);
    cmd_t cmd_w [NUM_SLOTS];

    // Purpose: command bit 4k+t sits at position k of slot transfer t.
    always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            cmd_w[s] = '0;
            for (int t = 0; t < SLOT_XFERS; t++) begin
                for (int k = 0; k < LANE_W; k++) begin
                    cmd_w[s][SLOT_XFERS*k + t] = lanes_i[(s*SLOT_XFERS + t)*LANE_W + k];
                end
            end
        end
    end

    assign cmd_a_o = cmd_w[0];
    assign cmd_b_o = cmd_w[1];
    assign cmd_c_o = cmd_w[2];

    // Purpose: gather the A check value and the frame type from slot A control bits.
    always_comb begin
        a_chk_o = '0;
        for (int t = 0; t < SLOT_XFERS; t++) begin
            for (int k = 1; k < CTL_W; k++) begin
                a_chk_o[SLOT_XFERS*(k-1) + t] = ctl_i[t*CTL_W + k];
            end
        end
        a_chk_o[12] = ctl_i[2*CTL_W];
        a_chk_o[13] = ctl_i[3*CTL_W];
        ftype_o     = {ctl_i[1*CTL_W], ctl_i[0]};
    end

    // Purpose: gather the frame check value from the B and C control bits.
    always_comb begin
        f_chk_o = '0;
        for (int t = SLOT_XFERS; t < FRAME_XFERS; t++) begin
            for (int k = 0; k < CTL_W; k++) begin
                if (CTL_W*(t-SLOT_XFERS) + k < CRC_F_W) begin
                    f_chk_o[CTL_W*(t-SLOT_XFERS) + k] = ctl_i[t*CTL_W + k];
                end
            end
        end
    end
endmodule

// File: rtl/sbd_chan_route.sv
// Module: registered steering of the issued commands onto the per-channel
// outputs. Command A wins a shared channel over an older B or C; a dropped
// older command is reported by a one-clock clash pulse. Assumes NCH <= 8.
module sbd_chan_route
    import sbd_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_a_i,
    input  cmd_t               cmd_a_i,
    input  logic               issue_bc_i,
    input  cmd_t               cmd_b_i,
    input  cmd_t               cmd_c_i,
    output logic [NCH-1:0]     chan_valid_o,
    output logic [NCH*CMD_W-1:0] chan_cmd_o,
    output logic               clash_o
);
    sel_t sel_a, sel_b, sel_c;
    assign sel_a = sel_of(cmd_a_i);
    assign sel_b = sel_of(cmd_b_i);
    assign sel_c = sel_of(cmd_c_i);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic hit_a, hit_b, hit_c;

        // Purpose: decide which issuing command, if any, lands on this channel.
        always_comb begin
            hit_a = issue_a_i  && (sel_a == sel_t'(ch));
            hit_b = issue_bc_i && (sel_b == sel_t'(ch));
            hit_c = issue_bc_i && (sel_c == sel_t'(ch));
        end

        // Purpose: register the strobe and the winning command of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chan_valid_o[ch]              <= 1'b0;
                chan_cmd_o[ch*CMD_W +: CMD_W] <= '0;
            end else begin
                chan_valid_o[ch] <= hit_a | hit_b | hit_c;
                if (hit_a) begin
                    chan_cmd_o[ch*CMD_W +: CMD_W] <= cmd_a_i;
                end else if (hit_b) begin
                    chan_cmd_o[ch*CMD_W +: CMD_W] <= cmd_b_i;
                end else if (hit_c) begin
                    chan_cmd_o[ch*CMD_W +: CMD_W] <= cmd_c_i;
                end
            end
        end
    end

    // Purpose: flag an older B or C displaced by a new A in the same clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clash_o <= 1'b0;
        end else begin
            clash_o <= issue_a_i && issue_bc_i &&
                       ((sel_b == sel_a) || (sel_c == sel_a));
        end
    end
endmodule

// File: rtl/sb_cmd_dispatch.sv
// Module: top of the southbound command dispatcher. Captures a twelve-transfer
// frame, checks the A-slot CRC on the fourth transfer and issues command A at
// once, checks the frame CRC on the last transfer and releases B and C one
// frame period after A. Assumes the transfers of a frame arrive on consecutive
// clocks and that the host keeps frames of one flow back to back or idle.
module sb_cmd_dispatch
    import sbd_pkg::*;
#(
    parameter int                 NCH        = 8,
    parameter int                 CNT_W      = 16,
    parameter logic [CRC_A_W-1:0] CRC_A_POLY = 14'h002B,
    parameter logic [CRC_F_W-1:0] CRC_F_POLY = 22'h000003
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   xfer_valid,
    input  logic                   frame_start,
    input  logic [XFER_W-1:0]      xfer_data,
    output logic [NCH-1:0]         chan_valid,
    output logic [NCH*CMD_W-1:0]   chan_cmd,
    output logic                   crc_a_err,
    output logic                   crc_f_err,
    output logic                   dimm_conflict,
    output logic                   chan_clash,
    output logic                   foreign_frame,
    output logic [CNT_W-1:0]       foreign_count
);
    localparam int WAIT_W  = $clog2(FRAME_XFERS + 1);
    localparam int A_BITS  = LANE_W + 1;
    localparam int LAST_A  = SLOT_XFERS - 1;
    localparam int LAST_F  = FRAME_XFERS - 1;

    // ---------------- transfer indexing ----------------
    logic [IDX_W-1:0] idx_q, cur_idx;
    logic             take;

    // Purpose: derive the index of the present transfer and whether it is taken.
    always_comb begin
        cur_idx = frame_start ? '0 : idx_q;
        take    = xfer_valid && (frame_start || (idx_q < IDX_W'(FRAME_XFERS)));
    end

    // Purpose: advance the transfer index; parked at FRAME_XFERS when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= IDX_W'(FRAME_XFERS);
        end else if (take) begin
            idx_q <= cur_idx + 1'b1;
        end
    end

    // ---------------- frame capture ----------------
    logic [LANE_W-1:0] lane_q [FRAME_XFERS];
    logic [CTL_W-1:0]  ctl_q  [FRAME_XFERS];
    logic [FRAME_XFERS*LANE_W-1:0] lanes_v;
    logic [FRAME_XFERS*CTL_W-1:0]  ctl_v;

    // Purpose: store each taken transfer in its frame position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < FRAME_XFERS; t++) begin
                lane_q[t] <= '0;
                ctl_q[t]  <= '0;
            end
        end else if (take) begin
            lane_q[cur_idx] <= xfer_data[LANE_W-1:0];
            ctl_q[cur_idx]  <= xfer_data[XFER_W-1:LANE_W];
        end
    end

    // Purpose: present the frame with the transfer now arriving already in place.
    always_comb begin
        for (int t = 0; t < FRAME_XFERS; t++) begin
            if (take && (cur_idx == IDX_W'(t))) begin
                lanes_v[t*LANE_W +: LANE_W] = xfer_data[LANE_W-1:0];
                ctl_v[t*CTL_W +: CTL_W]     = xfer_data[XFER_W-1:LANE_W];
            end else begin
                lanes_v[t*LANE_W +: LANE_W] = lane_q[t];
                ctl_v[t*CTL_W +: CTL_W]     = ctl_q[t];
            end
        end
    end

    cmd_t                 cmd_a, cmd_b, cmd_c;
    logic [CRC_A_W-1:0]   a_chk_rx;
    logic [CRC_F_W-1:0]   f_chk_rx;
    logic [FTYPE_W-1:0]   ftype;

    sbd_field_map u_map (
        .lanes_i (lanes_v),
        .ctl_i   (ctl_v),
        .cmd_a_o (cmd_a),
        .cmd_b_o (cmd_b),
        .cmd_c_o (cmd_c),
        .a_chk_o (a_chk_rx),
        .f_chk_o (f_chk_rx),
        .ftype_o (ftype)
    );

    // ---------------- CRC engines ----------------
    logic [CRC_A_W-1:0] crc_a_q, crc_a_seed, crc_a_nxt;
    logic [CRC_F_W-1:0] crc_f_q, crc_f_seed, crc_f_nxt;
    logic [A_BITS-1:0]  a_mask;

    // Purpose: restart both remainders on transfer 0; A covers the type bits early on.
    always_comb begin
        crc_a_seed = (cur_idx == '0) ? '0 : crc_a_q;
        crc_f_seed = (cur_idx == '0) ? '0 : crc_f_q;
        a_mask     = (cur_idx < IDX_W'(2)) ? {A_BITS{1'b1}} : {1'b0, {LANE_W{1'b1}}};
    end

    sbd_crc_step #(.W(CRC_A_W), .POLY(CRC_A_POLY), .NB(A_BITS)) u_crc_a (
        .crc_i  (crc_a_seed),
        .bits_i (xfer_data[A_BITS-1:0]),
        .mask_i (a_mask),
        .crc_o  (crc_a_nxt)
    );

    sbd_crc_step #(.W(CRC_F_W), .POLY(CRC_F_POLY), .NB(LANE_W)) u_crc_f (
        .crc_i  (crc_f_seed),
        .bits_i (xfer_data[LANE_W-1:0]),
        .mask_i ({LANE_W{1'b1}}),
        .crc_o  (crc_f_nxt)
    );

    // Purpose: hold the running remainders between transfers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_a_q <= '0;
            crc_f_q <= '0;
        end else if (take) begin
            if (cur_idx <= IDX_W'(LAST_A)) begin
                crc_a_q <= crc_a_nxt;
            end
            crc_f_q <= crc_f_nxt;
        end
    end

    // ---------------- issue control ----------------
    logic at_a_end, at_f_end, is_cmd, a_pass, f_pass, distinct;
    logic issue_a, a_fail, foreign_hit, f_fail, conflict_hit, bc_arm, issue_bc;
    logic a_ok_q, bc_pend_q;
    logic [WAIT_W-1:0] wait_q;
    cmd_t cmd_b_h, cmd_c_h;

    // Purpose: evaluate the A check at transfer 3 and the frame check at transfer 11.
    always_comb begin
        at_a_end     = take && (cur_idx == IDX_W'(LAST_A));
        at_f_end     = take && (cur_idx == IDX_W'(LAST_F));
        is_cmd       = (ftype == '0);
        a_pass       = (crc_a_nxt == a_chk_rx);
        f_pass       = (crc_f_nxt == f_chk_rx);
        distinct     = (sel_of(cmd_a) != sel_of(cmd_b)) &&
                       (sel_of(cmd_a) != sel_of(cmd_c)) &&
                       (sel_of(cmd_b) != sel_of(cmd_c));
        issue_a      = at_a_end && is_cmd && a_pass;
        a_fail       = at_a_end && is_cmd && !a_pass;
        foreign_hit  = at_a_end && !is_cmd;
        f_fail       = at_f_end && a_ok_q && !f_pass;
        conflict_hit = at_f_end && a_ok_q && f_pass && !distinct;
        bc_arm       = at_f_end && a_ok_q && f_pass && distinct;
        issue_bc     = bc_pend_q && (wait_q == WAIT_W'(1));
    end

    // Purpose: remember that this frame's A went out, so B and C may follow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_ok_q <= 1'b0;
        end else if (issue_a) begin
            a_ok_q <= 1'b1;
        end else if (take && (cur_idx == '0)) begin
            a_ok_q <= 1'b0;
        end
    end

    // Purpose: time one frame period from A issue to the B/C release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
        end else if (issue_a) begin
            wait_q <= WAIT_W'(FRAME_XFERS);
        end else if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
        end
    end

    // Purpose: hold checked B and C until their release clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bc_pend_q <= 1'b0;
            cmd_b_h   <= '0;
            cmd_c_h   <= '0;
        end else if (bc_arm) begin
            bc_pend_q <= 1'b1;
            cmd_b_h   <= cmd_b;
            cmd_c_h   <= cmd_c;
        end else if (issue_bc || issue_a) begin
            bc_pend_q <= 1'b0;
        end
    end

    // Purpose: register the status pulses and the non-command frame count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_a_err     <= 1'b0;
            crc_f_err     <= 1'b0;
            dimm_conflict <= 1'b0;
            foreign_frame <= 1'b0;
            foreign_count <= '0;
        end else begin
            crc_a_err     <= a_fail;
            crc_f_err     <= f_fail;
            dimm_conflict <= conflict_hit;
            foreign_frame <= foreign_hit;
            if (foreign_hit) begin
                foreign_count <= foreign_count + 1'b1;
            end
        end
    end

    sbd_chan_route #(.NCH(NCH)) u_route (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_a_i    (issue_a),
        .cmd_a_i      (cmd_a),
        .issue_bc_i   (issue_bc),
        .cmd_b_i      (cmd_b_h),
        .cmd_c_i      (cmd_c_h),
        .chan_valid_o (chan_valid),
        .chan_cmd_o   (chan_cmd),
        .clash_o      (chan_clash)
    );
endmodule

// File: rtl/sbd_checker.sv
// Module: property checker for the dispatcher, attached by bind. Observes the
// top-level ports only.
module sbd_checker #(
    parameter int NCH   = 8,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   chan_valid,
    input logic             crc_a_err,
    input logic             crc_f_err,
    input logic             dimm_conflict,
    input logic             chan_clash,
    input logic             foreign_frame,
    input logic [CNT_W-1:0] foreign_count
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (chan_valid == '0 && !crc_a_err && !crc_f_err && !foreign_frame && foreign_count == '0)); // R1

    AST_ISSUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chan_valid) <= 3); // R4

    AST_AERR_NOT_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
        crc_a_err |-> !foreign_frame); // R7

    AST_FERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        crc_f_err |=> !crc_f_err); // R5

    AST_FERR_NO_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        crc_f_err |-> !dimm_conflict); // R6

    AST_CLASH_HAS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        chan_clash |-> (chan_valid != '0)); // R8

    AST_FOREIGN_INC: assert property (@(posedge clk) disable iff (!rst_n)
        foreign_frame |-> foreign_count == $past(foreign_count) + 1'b1); // R7

    AST_FOREIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !foreign_frame |=> $stable(foreign_count) || foreign_frame); // R7
endmodule

bind sb_cmd_dispatch sbd_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_sbd_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .chan_valid    (chan_valid),
    .crc_a_err     (crc_a_err),
    .crc_f_err     (crc_f_err),
    .dimm_conflict (dimm_conflict),
    .chan_clash    (chan_clash),
    .foreign_frame (foreign_frame),
    .foreign_count (foreign_count)
);

// File: tb/sb_cmd_dispatch_tb_top.sv
// Bench: vector table of frames with expected outcomes, then directed tests
// for reset, back-to-back overlap and frame-start handling.
module sb_cmd_dispatch_tb_top;
    localparam int NCH = 8;
    typedef logic [11:0][9:0] frm_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         xfer_valid = 1'b0;
    logic         frame_start = 1'b0;
    logic [9:0]   xfer_data = '0;
    logic [NCH-1:0]    chan_valid;
    logic [NCH*24-1:0] chan_cmd;
    logic         crc_a_err, crc_f_err, dimm_conflict, chan_clash, foreign_frame;
    logic [15:0]  foreign_count;

    always #2 clk = ~clk;  // 250 MHz

    sb_cmd_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .frame_start(frame_start),
        .xfer_data(xfer_data), .chan_valid(chan_valid), .chan_cmd(chan_cmd),
        .crc_a_err(crc_a_err), .crc_f_err(crc_f_err), .dimm_conflict(dimm_conflict),
        .chan_clash(chan_clash), .foreign_frame(foreign_frame), .foreign_count(foreign_count)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0;
    int ev_cnt [NCH];
    int ev_cmd [NCH];
    int ev_cyc [NCH];
    int aerr_n, aerr_c, ferr_n, ferr_c, conf_n, conf_c, clash_n, clash_c, for_n, for_c;

    // Event log, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (chan_valid[ch]) begin
                    ev_cnt[ch]++;
                    ev_cmd[ch] = int'(chan_cmd[ch*24 +: 24]);
                    ev_cyc[ch] = cyc;
                end
            end
            if (crc_a_err)     begin aerr_n++;  aerr_c  = cyc; end
            if (crc_f_err)     begin ferr_n++;  ferr_c  = cyc; end
            if (dimm_conflict) begin conf_n++;  conf_c  = cyc; end
            if (chan_clash)    begin clash_n++; clash_c = cyc; end
            if (foreign_frame) begin for_n++;   for_c   = cyc; end
        end
    end

    task automatic clear_log();
        @(negedge clk);
        #1;
        for (int ch = 0; ch < NCH; ch++) begin
            ev_cnt[ch] = 0; ev_cmd[ch] = 0; ev_cyc[ch] = 0;
        end
        aerr_n = 0; ferr_n = 0; conf_n = 0; clash_n = 0; for_n = 0;
        aerr_c = 0; ferr_c = 0; conf_c = 0; clash_c = 0; for_c = 0;
    endtask

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [13:0] upd_a(input logic [13:0] r, input logic d);
        logic fb = r[13] ^ d;
        return {r[12:0], 1'b0} ^ (fb ? 14'h002B : 14'h0);
    endfunction

    function automatic logic [21:0] upd_f(input logic [21:0] r, input logic d);
        logic fb = r[21] ^ d;
        return {r[20:0], 1'b0} ^ (fb ? 22'h000003 : 22'h0);
    endfunction

    // Frame built from the layout stated in R2, R3, R5 and R7.
    function automatic frm_t build(input logic [23:0] a, input logic [23:0] b, input logic [23:0] c,
                                   input logic [1:0] ft, input logic ca, input logic cf);
        frm_t f = '0;
        logic [23:0] cm [3];
        logic [13:0] ra = '0;
        logic [21:0] rf = '0;
        cm[0] = a; cm[1] = b; cm[2] = c;
        for (int s = 0; s < 3; s++)
            for (int t = 0; t < 4; t++)
                for (int k = 0; k < 6; k++)
                    f[s*4+t][k] = cm[s][4*k+t];
        f[0][6] = ft[0];
        f[1][6] = ft[1];
        for (int t = 0; t < 4; t++)
            for (int k = 0; k < ((t < 2) ? 7 : 6); k++)
                ra = upd_a(ra, f[t][k]);
        if (ca) ra[0] = ~ra[0];
        for (int j = 0; j < 12; j++) f[j%4][7 + j/4] = ra[j];
        f[2][6] = ra[12];
        f[3][6] = ra[13];
        for (int t = 0; t < 12; t++)
            for (int k = 0; k < 6; k++)
                rf = upd_f(rf, f[t][k]);
        if (cf) rf[0] = ~rf[0];
        for (int i = 0; i < 22; i++) f[4 + i/4][6 + i%4] = rf[i];
        return f;
    endfunction

    task automatic send_frame(input frm_t f, input logic with_start, output int t3c);
        t3c = 0;
        for (int t = 0; t < 12; t++) begin
            @(negedge clk);
            xfer_valid  = 1'b1;
            frame_start = with_start && (t == 0);
            xfer_data   = f[t];
            if (t == 3) t3c = cyc + 1;
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        xfer_valid = 1'b0; frame_start = 1'b0; xfer_data = '0;
        repeat (n) @(negedge clk);
    endtask

    function automatic int sel(input logic [23:0] c);
        return int'(c[23:21]);
    endfunction

    function automatic int total_ev();
        int s = 0;
        for (int ch = 0; ch < NCH; ch++) s += ev_cnt[ch];
        return s;
    endfunction

    // {cmdA, cmdB, cmdC, ftype, badA, badF, expA, expBC, expAerr, expFerr, expConf, expForeign}
    localparam logic [81:0] VEC [9] = '{
        {24'h2A5F31, 24'h4C0FFE, 24'hA13579, 2'b00, 1'b0, 1'b0, 6'b110000},
        {24'hF00D12, 24'h0BEEF0, 24'h6789AB, 2'b00, 1'b0, 1'b0, 6'b110000},
        {24'h712345, 24'h8ABCDE, 24'hC55AA5, 2'b00, 1'b1, 1'b0, 6'b001000},
        {24'hB0B0B0, 24'hD12121, 24'h1FFFFF, 2'b00, 1'b0, 1'b1, 6'b100100},
        {24'h9ABCDE, 24'h400001, 24'h8FEDCB, 2'b00, 1'b0, 1'b0, 6'b100010},
        {24'h012345, 24'hC00000, 24'hDFFFFF, 2'b00, 1'b0, 1'b0, 6'b100010},
        {24'h2A5F31, 24'h4C0FFE, 24'hA13579, 2'b01, 1'b0, 1'b0, 6'b000001},
        {24'h712345, 24'h8ABCDE, 24'hC55AA5, 2'b10, 1'b1, 1'b0, 6'b000001},
        {24'hFFFFFF, 24'h000000, 24'h555555, 2'b00, 1'b0, 1'b0, 6'b110000}
    };

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int t3c, t3p, t3q, t3r;
        // ---- R1: reset state, with a stray transfer offered during reset ----
        repeat (3) @(negedge clk);
        xfer_valid = 1'b1; frame_start = 1'b1; xfer_data = 10'h3FF;
        @(negedge clk);
        chk("R1", "chan_valid in reset", chan_valid, 0);
        chk("R1", "foreign_count in reset", foreign_count, 0);
        xfer_valid = 1'b0; frame_start = 1'b0; xfer_data = '0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "chan_valid after reset", chan_valid, 0);
        chk("R1", "pulses after reset",
            {crc_a_err, crc_f_err, dimm_conflict, chan_clash, foreign_frame}, 0);
        chk("R1", "foreign_count after reset", foreign_count, 0);

        // ---- vector table: R2..R7 ----
        for (int v = 0; v < 9; v++) begin
            logic [23:0] ca_, cb_, cc_;
            logic [1:0]  ft;
            logic        ba, bf, eA, eBC, eAe, eFe, eCo, eFo;
            {ca_, cb_, cc_, ft, ba, bf, eA, eBC, eAe, eFe, eCo, eFo} = VEC[v];
            clear_log();
            send_frame(build(ca_, cb_, cc_, ft, ba, bf), 1'b1, t3c);
            idle(20);
            chk("R2", $sformatf("vec%0d issue count", v), total_ev(), int'(eA) + 2*int'(eBC));
            if (eA) begin
                chk("R2", $sformatf("vec%0d A cmd", v), ev_cmd[sel(ca_)], ca_);
                chk("R2", $sformatf("vec%0d A cycle", v), ev_cyc[sel(ca_)], t3c);
            end
            if (eBC) begin
                chk("R4", $sformatf("vec%0d B cmd", v), ev_cmd[sel(cb_)], cb_);
                chk("R4", $sformatf("vec%0d B cycle", v), ev_cyc[sel(cb_)], t3c + 12);
                chk("R4", $sformatf("vec%0d C cmd", v), ev_cmd[sel(cc_)], cc_);
                chk("R4", $sformatf("vec%0d C cycle", v), ev_cyc[sel(cc_)], t3c + 12);
            end
            chk("R3", $sformatf("vec%0d crc_a_err count", v), aerr_n, eAe);
            if (eAe) chk("R3", $sformatf("vec%0d crc_a_err cycle", v), aerr_c, t3c);
            chk("R5", $sformatf("vec%0d crc_f_err count", v), ferr_n, eFe);
            if (eFe) chk("R5", $sformatf("vec%0d crc_f_err cycle", v), ferr_c, t3c + 8);
            chk("R6", $sformatf("vec%0d conflict count", v), conf_n, eCo);
            if (eCo) chk("R6", $sformatf("vec%0d conflict cycle", v), conf_c, t3c + 8);
            chk("R7", $sformatf("vec%0d foreign count", v), for_n, eFo);
            if (eFo) chk("R7", $sformatf("vec%0d foreign cycle", v), for_c, t3c);
        end
        chk("R7", "foreign_count after table", foreign_count, 2);

        // ---- R8: back-to-back overlap of new A with older B/C ----
        clear_log();
        send_frame(build(24'h011111, 24'h222222, 24'h444444, 2'b00, 1'b0, 1'b0), 1'b1, t3p);
        send_frame(build(24'h666666, 24'h888888, 24'hAAAAAA, 2'b00, 1'b0, 1'b0), 1'b1, t3q);
        send_frame(build(24'h899999, 24'hCCCCCC, 24'hEEEEEE, 2'b00, 1'b0, 1'b0), 1'b1, t3r);
        idle(24);
        chk("R8", "P.B cycle equals Q.A cycle", ev_cyc[1], ev_cyc[3]);
        chk("R8", "Q.A cycle", ev_cyc[3], t3q);
        chk("R8", "P.C cmd", ev_cmd[2], 24'h444444);
        chk("R8", "shared channel count", ev_cnt[4], 1);
        chk("R8", "shared channel holds new A", ev_cmd[4], 24'h899999);
        chk("R8", "shared channel cycle", ev_cyc[4], t3r);
        chk("R8", "Q.C delivered beside clash", ev_cmd[5], 24'hAAAAAA);
        chk("R8", "Q.C cycle", ev_cyc[5], t3r);
        chk("R8", "clash pulses", clash_n, 1);
        chk("R8", "clash cycle", clash_c, t3r);
        chk("R8", "R.C after overlap", ev_cmd[7], 24'hEEEEEE);
        chk("R8", "total issues", total_ev(), 8);

        // ---- R9: no frame-start -> ignored ----
        clear_log();
        send_frame(build(24'h2A5F31, 24'h4C0FFE, 24'hA13579, 2'b00, 1'b0, 1'b0), 1'b0, t3c);
        idle(20);
        chk("R9", "no issue without frame-start", total_ev(), 0);
        chk("R9", "no pulse without frame-start", aerr_n + ferr_n + conf_n + for_n, 0);

        // ---- R9: mid-frame restart ----
        clear_log();
        @(negedge clk);
        xfer_valid = 1'b1; frame_start = 1'b1; xfer_data = 10'h2C3;
        @(negedge clk);
        frame_start = 1'b0; xfer_data = 10'h1A5;
        send_frame(build(24'h2A5F31, 24'h4C0FFE, 24'hA13579, 2'b00, 1'b0, 1'b0), 1'b1, t3c);
        idle(20);
        chk("R9", "restart A cycle", ev_cyc[1], t3c);
        chk("R9", "restart C cmd", ev_cmd[5], 24'hA13579);
        chk("R9", "restart issue count", total_ev(), 3);
        chk("R9", "restart no errors", aerr_n + ferr_n + conf_n, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule